// File: doc/BRIEF.md
# Transmitter Fail-Safe Timeout Monitor

This block sits beside a serial bus encoder and measures how long the current outgoing message has lasted. It counts system clocks while the encoder reports transmit activity. Short idle gaps inside a message are bridged, and their clocks still count toward the length. A gap is bridged even when it comes from a master-reset pulse. Only a gap longer than the bridge limit ends the message and restarts the count at zero.

When a message runs past the length limit, the block raises a fail-safe flag and asserts an output-kill control. The control holds both transmit line drivers low and blocks any further transmission. The flag latches and has no timeout. It is released only by a received command carrying this terminal's own address, or by a master-reset low that lasts at least the qualifying time. All limits are given in microseconds and scaled by the clocks per microsecond. The defaults are a 12-clock microsecond, a 768 µs limit (9216 clocks), a 3 µs gap bridge (36 clocks) and a 1 µs reset qualification (12 clocks).

Top module: `txfs_monitor`

## Requirements
- R1: With transmit activity high on every clock from idle, the flag stays low after 9216 such clocks and is high after the 9217th.
- R2: The output-kill control is high exactly when the fail-safe flag is high.
- R3: A high own-address command sampled at a clock edge makes the flag low after that edge. It wins over a limit crossing in the same cycle.
- R4: A master-reset input held low for 12 consecutive clocks clears the flag. A low run of 11 clocks leaves the flag unchanged.
- R5: An idle gap of up to 36 clocks between transmit clocks is bridged, and the gap clocks add to the message length.
- R6: An idle gap of 37 or more clocks ends the message, so the next transmit activity starts counting from zero.
- R7: Once set, the flag stays high with no timeout, whatever the transmit activity, until one of the clearing events of R3 or R4 occurs.
- R8: Master-reset activity does not restart the length count. A gap of 36 clocks or less caused by a reset pulse is bridged like any other gap.
- R9: After the power-on reset the flag and the kill control are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLKS_PER_US clocks per microsecond) |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tx_active | input | 1 | High while the encoder is shifting a word onto the line |
| own_cmd | input | 1 | One-clock pulse: valid command with this terminal's address received |
| mrst_n | input | 1 | Master reset from the subsystem, active low |
| fs_flag | output | 1 | Latched fail-safe flag |
| tx_kill | output | 1 | Forces both transmit lines low and blocks transmission |

## Verification
The hardest case to reach is a message that lands exactly on the limit after one or more bridged gaps. The case is harder still when a master-reset pulse opened the gap. The stimulus builds such messages from transmit runs and idle runs whose sums are worked out to be one clock below the limit and then one clock over it. It also uses a gap one clock too long, to show the count restarting. A behavioural model in the bench tracks message length and idle runs with plain integers and is compared with the outputs on every clock. Targeted checks cover the 11-versus-12-clock reset qualification and the same-cycle race between a limit crossing and an own-address command.

// File: rtl/txfs_pkg.sv
package txfs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SEND   = 2'd1,
        PH_BRIDGE = 2'd2
    } txfs_phase_e;
endpackage

// File: rtl/txfs_msg_timer.sv
module txfs_msg_timer
    import txfs_pkg::*;
#(
    parameter int LIMIT_CLKS = 9216,
    parameter int GAP_CLKS   = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    output logic trip
);
    localparam int MW = $clog2(LIMIT_CLKS + 1);
    localparam int GW = $clog2(GAP_CLKS + 1);

    typedef struct packed {
        txfs_phase_e   ph;
        logic [MW-1:0] msg;
        logic [GW-1:0] gap;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [MW-1:0] msg_inc;

    always_comb begin
        msg_inc = (st_q.msg == MW'(LIMIT_CLKS)) ? st_q.msg : st_q.msg + MW'(1);
        st_d    = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (tx_active) begin
                    st_d.ph  = PH_SEND;
                    st_d.msg = MW'(1);
                    st_d.gap = '0;
                end
            end
            PH_SEND: begin
                st_d.msg = msg_inc;
                if (!tx_active) begin
                    st_d.ph  = PH_BRIDGE;
                    st_d.gap = GW'(1);
                end
            end
            PH_BRIDGE: begin
                if (tx_active) begin
                    st_d.ph  = PH_SEND;
                    st_d.gap = '0;
                    st_d.msg = msg_inc;
                end else if (st_q.gap >= GW'(GAP_CLKS)) begin
                    st_d.ph  = PH_IDLE;
                    st_d.gap = '0;
                    st_d.msg = '0;
                end else begin
                    st_d.gap = st_q.gap + GW'(1);
                    st_d.msg = msg_inc;
                end
            end
            default: st_d = '{ph: PH_IDLE, msg: '0, gap: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, msg: '0, gap: '0};
        else        st_q <= st_d;
    end

    assign trip = tx_active && (st_q.msg >= MW'(LIMIT_CLKS));

    // R5: a bridged gap never runs past its limit
    a_r5_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gap <= GW'(GAP_CLKS));
    // R6: an ended message holds no residual length
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE) |-> (st_q.msg == '0));
    // R6: a gap at its limit with no activity drops to idle
    a_r6_gap_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_BRIDGE && st_q.gap == GW'(GAP_CLKS) && !tx_active)
        |=> (st_q.ph == PH_IDLE));
endmodule

// File: rtl/txfs_reset_qual.sv
module txfs_reset_qual #(
    parameter int MIN_CLKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mrst_n,
    output logic rst_ok
);
    localparam int CW = $clog2(MIN_CLKS + 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mrst_n)                          st_d.run = '0;
        else if (st_q.run != CW'(MIN_CLKS))  st_d.run = st_q.run + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: '0};
        else        st_q <= st_d;
    end

    assign rst_ok = !mrst_n && (st_q.run >= CW'(MIN_CLKS - 1));

    // R4: a released master reset restarts qualification
    a_r4_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
        mrst_n |=> (st_q.run == '0));
endmodule

// File: rtl/txfs_flag_latch.sv
module txfs_flag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr_own,
    input  logic clr_rst,
    output logic flag
);
    typedef struct packed {
        logic fs;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_own || clr_rst) st_d.fs = 1'b0;
        else if (trip)          st_d.fs = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{fs: 1'b0};
        else        st_q <= st_d;
    end

    assign flag = st_q.fs;

    // R7: no release without a clearing event
    a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fs && !clr_own && !clr_rst) |=> st_q.fs);
endmodule

// File: rtl/txfs_monitor.sv
module txfs_monitor #(
    parameter int CLKS_PER_US = 12,
    parameter int LIMIT_US    = 768,
    parameter int GAP_US      = 3,
    parameter int MRST_MIN_US = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic own_cmd,
    input  logic mrst_n,
    output logic fs_flag,
    output logic tx_kill
);
    localparam int LIMIT_CLKS = CLKS_PER_US * LIMIT_US;
    localparam int GAP_CLKS   = CLKS_PER_US * GAP_US;
    localparam int MRST_CLKS  = CLKS_PER_US * MRST_MIN_US;

    logic trip, rst_ok;

    txfs_msg_timer #(.LIMIT_CLKS(LIMIT_CLKS), .GAP_CLKS(GAP_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .trip(trip));

    txfs_reset_qual #(.MIN_CLKS(MRST_CLKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n), .rst_ok(rst_ok));

    txfs_flag_latch u_latch (
        .clk(clk), .rst_n(rst_n), .trip(trip), .clr_own(own_cmd),
        .clr_rst(rst_ok), .flag(fs_flag));

    assign tx_kill = fs_flag;

    // R1: the flag only rises out of transmit activity
    a_r1_rise_on_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_flag) |-> $past(tx_active));
    // R3: an own-address command always leaves the flag low
    a_r3_own_clears: assert property (@(posedge clk) disable iff (!rst_n)
        own_cmd |=> !fs_flag);
    // R4: the flag falls only after a clearing event
    a_r4_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fs_flag) |-> ($past(own_cmd) || $past(!mrst_n)));
endmodule

// File: tb/txfs_monitor_bench.sv
module txfs_monitor_bench;
    localparam int LIM = 9216;
    localparam int GAP = 36;
    localparam int RQ  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0;
    logic own_cmd = 1'b0;
    logic mrst_n = 1'b1;
    logic fs_flag, tx_kill;

    int n_run = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference
    int  m_len = 0;
    int  m_idle = 0;
    bit  m_in = 1'b0;
    int  m_lo = 0;
    bit  m_fs = 1'b0;

    always #10 clk = ~clk;

    txfs_monitor u_txfs_monitor (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .own_cmd(own_cmd),
        .mrst_n(mrst_n), .fs_flag(fs_flag), .tx_kill(tx_kill));

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 0; m_idle = 0; m_in = 1'b0; m_lo = 0; m_fs = 1'b0;
        end else begin
            bit over;
            bit qual;
            over = tx_active && (m_len >= LIM);
            m_lo = mrst_n ? 0 : m_lo + 1;
            qual = (m_lo >= RQ);
            if (own_cmd || qual) m_fs = 1'b0;
            else if (over)       m_fs = 1'b1;
            if (tx_active) begin
                m_in = 1'b1; m_idle = 0; m_len = m_len + 1;
            end else if (m_in) begin
                m_idle = m_idle + 1;
                if (m_idle > GAP) begin
                    m_in = 1'b0; m_idle = 0; m_len = 0;
                end else begin
                    m_len = m_len + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            n_run++;
            if (fs_flag !== m_fs || tx_kill !== m_fs) begin
                n_fail++;
                $display("FAIL R2 model compare: flag=%0b kill=%0b expected %0b",
                         fs_flag, tx_kill, m_fs);
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // drive n clocks of a pattern; inputs change on falling edges
    task automatic drive(input int n, input logic tx, input logic mr, input logic own);
        for (int i = 0; i < n; i++) begin
            tx_active = tx; mrst_n = mr; own_cmd = own;
            @(negedge clk);
        end
        tx_active = 1'b0; mrst_n = 1'b1; own_cmd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(fs_flag, 1'b0, "R9 flag after reset");
        check(tx_kill, 1'b0, "R9 kill after reset");
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);

        // R1 boundary
        drive(LIM, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b0, "R1 at limit");
        drive(1, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b1, "R1 past limit");
        check(tx_kill, 1'b1, "R2 kill follows flag");

        // R7 no timeout
        drive(500, 1'b0, 1'b1, 1'b0);
        check(fs_flag, 1'b1, "R7 held while idle");
        drive(300, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b1, "R7 held under activity");

        // R4 qualification
        drive(40, 1'b0, 1'b1, 1'b0);
        drive(RQ - 1, 1'b0, 1'b0, 1'b0);
        check(fs_flag, 1'b1, "R4 short reset ignored");
        drive(RQ, 1'b0, 1'b0, 1'b0);
        check(fs_flag, 1'b0, "R4 qualified reset clears");
        check(tx_kill, 1'b0, "R2 kill released");

        // R5 bridged gap of 36
        drive(50, 1'b0, 1'b1, 1'b0);
        drive(5000, 1'b1, 1'b1, 1'b0);
        drive(GAP, 1'b0, 1'b1, 1'b0);
        drive(LIM - 5000 - GAP, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b0, "R5 bridged at limit");
        drive(1, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b1, "R5 bridged past limit");
        drive(1, 1'b0, 1'b1, 1'b1);
        check(fs_flag, 1'b0, "R3 own command clears");

        // R6 gap of 37 restarts
        drive(50, 1'b0, 1'b1, 1'b0);
        drive(5000, 1'b1, 1'b1, 1'b0);
        drive(GAP + 1, 1'b0, 1'b1, 1'b0);
        drive(LIM, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b0, "R6 restart after long gap");
        drive(1, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b1, "R6 fresh message trips");
        drive(1, 1'b0, 1'b1, 1'b1);
        check(fs_flag, 1'b0, "R3 clear again");

        // R8 reset-caused gap bridged
        drive(50, 1'b0, 1'b1, 1'b0);
        drive(5000, 1'b1, 1'b1, 1'b0);
        drive(20, 1'b0, 1'b0, 1'b0);
        drive(10, 1'b0, 1'b1, 1'b0);
        drive(LIM - 5000 - 30, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b0, "R8 reset gap at limit");
        drive(1, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b1, "R8 reset gap bridged");
        drive(1, 1'b0, 1'b1, 1'b1);

        // R3 priority over a same-cycle crossing
        drive(50, 1'b0, 1'b1, 1'b0);
        drive(LIM, 1'b1, 1'b1, 1'b0);
        drive(1, 1'b1, 1'b1, 1'b1);
        check(fs_flag, 1'b0, "R3 own wins over crossing");
        drive(1, 1'b1, 1'b1, 1'b0);
        check(fs_flag, 1'b1, "R1 crossing after own");
        drive(20, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule